// File: doc/BRIEF.md
# Machine-Cycle Sampled Reset Generator

This block turns a raw, asynchronous, active-high reset pin into the internal reset of a core whose machine cycle lasts 12 clocks. The pin first passes through a two-flop synchronizer. The synchronized level is then looked at only once per machine cycle, at a fixed phase. Internal reset starts only after two samples in a row read high. It ends at the first sample that reads low.

A short glitch that is caught by one sample does nothing. A pin held high for two full machine cycles always produces a reset. During reset the stack pointer and the general register bank take their reset values. The port latches keep driving their current values for a short window measured from the first high sample, and are then forced to all ones. The serial buffer is never touched by reset. While reset is active, the core cannot write to any of these registers.

A separate power-on clear (`powerOnN`) initialises the generator's own flops and the register bank, and aligns the machine-cycle phase counter.

Top module: `mc_reset_gen`

## Requirements
- R1: The pin is re-timed by two flops and sampled once every 12 clocks, at the edge where the phase counter reads SAMPLE_PHASE. The phase counter reads 0 at the first edge after `powerOnN` rises and then counts 0 to 11 and wraps. `sysRst` changes only on a sampling edge. When the pin rises just before a clock edge, `sysRst` goes high 15 to 26 clock edges later.
- R2: `sysRst` rises only on the second of two consecutive high samples. A pin pattern that gives a single high sample has no effect on `sysRst`, `portRst` or any register: for example a 12-clock pulse, or high–low–high with 12-clock segments. A pin held high for 24 clocks always produces a reset.
- R3: `portRst` rises PORT_DELAY (19) clocks after the first high sample, which is exactly 7 clocks after `sysRst` rises. Until then every port latch keeps its value. While `portRst` is high, every port latch reads FFh.
- R4: Reset ends at the first low sample. `sysRst` and `portRst` fall on the same edge, 3 to 14 clock edges after the pin falls.
- R5: While `sysRst` is high, the stack pointer loads 07h and every register of the general bank loads 00h. Each is valid from the clock after `sysRst` rises.
- R6: The serial buffer keeps its value through reset.
- R7: Writes (`wrEn`) are ignored in every cycle in which `sysRst` is high.
- R8: Outside reset, a write takes effect at the next clock edge. The address map is:
  - 0 to NUM_PORTS-1: port latches
  - NUM_PORTS: stack pointer
  - NUM_PORTS+1: serial buffer
  - NUM_PORTS+2 upward: general bank

  With the defaults the general bank sits at addresses 6 to 9. After power-on clear, the ports read FFh, the stack pointer 07h, and the serial buffer and general bank 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| powerOnN | input | 1 | Asynchronous power-on clear, active low |
| rstPin | input | 1 | Raw asynchronous reset pin, active high |
| wrEn | input | 1 | Core register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 8 | Register write data |
| sysRst | output | 1 | Internal core reset |
| portRst | output | 1 | Port latches forced to FFh |
| portsOut | output | NUM_PORTS*8 | Port latch values, port 0 in the low byte |
| spOut | output | 8 | Stack pointer value |
| sbufOut | output | 8 | Serial buffer value |
| sfrOut | output | NUM_SFR*8 | General register bank, entry 0 in the low byte |

## Verification
A wrong sample phase or a lost "previous sample high" flag shows up at `sysRst` within one machine cycle, as a reset that starts too early, too late, or on a single-sample glitch. A port-hold counter that starts or stops on the wrong edge moves the `portRst` rise away from exactly 7 clocks after `sysRst`. It can also change the port values during a rejected glitch. A missing write gate or a wrong reset value appears on the register outputs one clock after `sysRst` rises.

// File: rtl/rg_pkg.sv
package rg_pkg;
  typedef struct packed {
    logic coreRst;
    logic portForce;
  } rg_strobe_t;

  localparam logic [7:0] PORT_RST_VAL = 8'hFF;
  localparam logic [7:0] SP_RST_VAL   = 8'h07;
  localparam logic [7:0] SFR_RST_VAL  = 8'h00;
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl #(
  parameter int CYCLE_LEN    = 12,
  parameter int SAMPLE_PHASE = 9,
  parameter int PORT_DELAY   = 19
) (
  input  logic               clk,
  input  logic               powerOnN,
  input  logic               rstPin,
  output rg_pkg::rg_strobe_t strobes,
  output logic               sampleTick,
  output logic               syncPin
);
  localparam int PH_W   = $clog2(CYCLE_LEN);
  localparam int HOLD_W = $clog2(PORT_DELAY + 1);

  logic [1:0]        syncReg;
  logic [PH_W-1:0]   phase;
  logic              prevHigh;
  logic              rstActive;
  logic              holdRun;
  logic [HOLD_W-1:0] holdCnt;
  logic              portForce;

  // two-flop re-timing of the raw pin
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) syncReg <= 2'b00;
    else           syncReg <= {syncReg[0], rstPin};
  end

  // machine-cycle phase
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)                             phase <= '0;
    else if (phase == PH_W'(CYCLE_LEN - 1))    phase <= '0;
    else                                       phase <= phase + 1'b1;
  end

  assign syncPin    = syncReg[1];
  assign sampleTick = (phase == PH_W'(SAMPLE_PHASE));

  // sample qualification and port hold window
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      prevHigh  <= 1'b0;
      rstActive <= 1'b0;
      holdRun   <= 1'b0;
      holdCnt   <= '0;
      portForce <= 1'b0;
    end else begin
      if (holdRun) begin
        if (holdCnt == HOLD_W'(PORT_DELAY)) begin
          portForce <= 1'b1;
          holdRun   <= 1'b0;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
      if (sampleTick) begin
        if (syncPin) begin
          prevHigh <= 1'b1;
          if (prevHigh) begin
            rstActive <= 1'b1;
          end else begin
            holdRun <= 1'b1;
            holdCnt <= HOLD_W'(1);
          end
        end else begin
          prevHigh  <= 1'b0;
          rstActive <= 1'b0;
          holdRun   <= 1'b0;
          portForce <= 1'b0;
        end
      end
    end
  end

  assign strobes.coreRst   = rstActive;
  assign strobes.portForce = portForce;
endmodule

// File: rtl/rg_datapath.sv
module rg_datapath #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_SFR   = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   powerOnN,
  input  rg_pkg::rg_strobe_t     strobes,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  output logic [NUM_PORTS*8-1:0] portsOut,
  output logic [7:0]             spOut,
  output logic [7:0]             sbufOut,
  output logic [NUM_SFR*8-1:0]   sfrOut
);
  import rg_pkg::*;

  localparam int SP_ADDR   = NUM_PORTS;
  localparam int SBUF_ADDR = NUM_PORTS + 1;
  localparam int SFR_BASE  = NUM_PORTS + 2;

  logic wrOk;
  logic [7:0] spReg;
  logic [7:0] sbufReg;

  assign wrOk = wrEn && !strobes.coreRst;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [7:0] portReg;
    always_ff @(posedge clk or negedge powerOnN) begin
      if (!powerOnN)                              portReg <= PORT_RST_VAL;
      else if (strobes.portForce)                 portReg <= PORT_RST_VAL;
      else if (wrOk && wrAddr == ADDR_W'(p))      portReg <= wrData;
    end
    assign portsOut[p*8 +: 8] = portReg;
  end

  for (genvar s = 0; s < NUM_SFR; s++) begin : g_sfr
    logic [7:0] sfrReg;
    always_ff @(posedge clk or negedge powerOnN) begin
      if (!powerOnN)                                  sfrReg <= SFR_RST_VAL;
      else if (strobes.coreRst)                       sfrReg <= SFR_RST_VAL;
      else if (wrOk && wrAddr == ADDR_W'(SFR_BASE + s)) sfrReg <= wrData;
    end
    assign sfrOut[s*8 +: 8] = sfrReg;
  end

  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)                               spReg <= SP_RST_VAL;
    else if (strobes.coreRst)                    spReg <= SP_RST_VAL;
    else if (wrOk && wrAddr == ADDR_W'(SP_ADDR)) spReg <= wrData;
  end

  // serial buffer: reset never touches it
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)                                 sbufReg <= 8'h00;
    else if (wrOk && wrAddr == ADDR_W'(SBUF_ADDR)) sbufReg <= wrData;
  end

  assign spOut   = spReg;
  assign sbufOut = sbufReg;
endmodule

// File: rtl/mc_reset_gen.sv
module mc_reset_gen #(
  parameter int CYCLE_LEN    = 12,
  parameter int SAMPLE_PHASE = 9,
  parameter int PORT_DELAY   = 19,
  parameter int NUM_PORTS    = 4,
  parameter int NUM_SFR      = 4,
  parameter int ADDR_W       = 4
) (
  input  logic                   clk,
  input  logic                   powerOnN,
  input  logic                   rstPin,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  output logic                   sysRst,
  output logic                   portRst,
  output logic [NUM_PORTS*8-1:0] portsOut,
  output logic [7:0]             spOut,
  output logic [7:0]             sbufOut,
  output logic [NUM_SFR*8-1:0]   sfrOut
);
  rg_pkg::rg_strobe_t strobes;
  logic sampleTick;
  logic syncPin;

  rg_ctrl #(
    .CYCLE_LEN(CYCLE_LEN), .SAMPLE_PHASE(SAMPLE_PHASE), .PORT_DELAY(PORT_DELAY)
  ) i_ctrl (
    .clk(clk), .powerOnN(powerOnN), .rstPin(rstPin),
    .strobes(strobes), .sampleTick(sampleTick), .syncPin(syncPin)
  );

  rg_datapath #(
    .NUM_PORTS(NUM_PORTS), .NUM_SFR(NUM_SFR), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .powerOnN(powerOnN), .strobes(strobes),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .portsOut(portsOut), .spOut(spOut), .sbufOut(sbufOut), .sfrOut(sfrOut)
  );

  assign sysRst  = strobes.coreRst;
  assign portRst = strobes.portForce;
endmodule

// File: rtl/rg_checker.sv
module rg_checker #(
  parameter int PORTS_W = 32,
  parameter int SFR_W   = 32
) (
  input logic               clk,
  input logic               powerOnN,
  input logic               sysRst,
  input logic               portRst,
  input logic               sampleTick,
  input logic               syncPin,
  input logic [PORTS_W-1:0] portsOut,
  input logic [7:0]         spOut,
  input logic [7:0]         sbufOut,
  input logic [SFR_W-1:0]   sfrOut
);
  p_change_on_sample_r1: assert property (@(posedge clk) disable iff (!powerOnN)
    !$stable(sysRst) |-> $past(sampleTick));

  p_rise_on_high_sample_r2: assert property (@(posedge clk) disable iff (!powerOnN)
    $rose(sysRst) |-> $past(sampleTick && syncPin));

  p_port_after_core_r3: assert property (@(posedge clk) disable iff (!powerOnN)
    $rose(sysRst) |-> !portRst);

  p_ports_forced_r3: assert property (@(posedge clk) disable iff (!powerOnN)
    $past(portRst) |-> (portsOut == {PORTS_W{1'b1}}));

  p_port_inside_core_r4: assert property (@(posedge clk) disable iff (!powerOnN)
    portRst |-> sysRst);

  p_reset_values_r5: assert property (@(posedge clk) disable iff (!powerOnN)
    $past(sysRst) |-> (spOut == 8'h07 && sfrOut == '0));

  p_sbuf_kept_r6: assert property (@(posedge clk) disable iff (!powerOnN)
    $past(sysRst) |-> $stable(sbufOut));
endmodule

bind mc_reset_gen rg_checker #(
  .PORTS_W(NUM_PORTS * 8), .SFR_W(NUM_SFR * 8)
) i_rg_checker (
  .clk(clk), .powerOnN(powerOnN), .sysRst(sysRst), .portRst(portRst),
  .sampleTick(sampleTick), .syncPin(syncPin), .portsOut(portsOut),
  .spOut(spOut), .sbufOut(sbufOut), .sfrOut(sfrOut)
);

// File: tb/test_mc_reset_gen.sv
`timescale 1ns/1ps
module test_mc_reset_gen;
  localparam int NP = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic powerOnN = 1'b0;
  logic rstPin = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic sysRst, portRst;
  logic [NP*8-1:0] portsOut;
  logic [7:0] spOut, sbufOut;
  logic [NS*8-1:0] sfrOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NP*8-1:0] portsSaved;
  logic [NS*8-1:0] sfrSaved;

  always #10 clk = ~clk;

  mc_reset_gen i_mc_reset_gen (
    .clk(clk), .powerOnN(powerOnN), .rstPin(rstPin), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .sysRst(sysRst), .portRst(portRst),
    .portsOut(portsOut), .spOut(spOut), .sbufOut(sbufOut), .sfrOut(sfrOut)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic test_power_on;
    tick(2);
    chk(sysRst == 1'b0 && portRst == 1'b0, "R8 power-on strobes", {sysRst, portRst}, 0);
    chk(portsOut == '1, "R8 power-on ports", portsOut, 32'hFFFFFFFF);
    chk(spOut == 8'h07, "R8 power-on sp", spOut, 8'h07);
    chk(sfrOut == '0 && sbufOut == 8'h00, "R8 power-on bank", sfrOut, 0);
  endtask

  task automatic test_writes;
    for (int i = 0; i < NP; i++) wr(4'(i), 8'h10 + 8'(i));
    wr(4'd4, 8'h55);
    wr(4'd5, 8'hA5);
    for (int i = 0; i < NS; i++) wr(4'(6 + i), 8'h30 + 8'(i));
    chk(portsOut == 32'h13121110, "R8 port writes", portsOut, 32'h13121110);
    chk(spOut == 8'h55, "R8 sp write", spOut, 8'h55);
    chk(sbufOut == 8'hA5, "R8 sbuf write", sbufOut, 8'hA5);
    chk(sfrOut == 32'h33323130, "R8 bank write", sfrOut, 32'h33323130);
  endtask

  // pin pattern given as high/low run lengths; a single sample reads high
  task automatic test_glitch(input int hi1, input int lo1, input int hi2, input string tag);
    bit sawRst;
    sawRst = 1'b0;
    portsSaved = portsOut;
    sfrSaved = sfrOut;
    rstPin = 1'b1; for (int i = 0; i < hi1; i++) begin tick(1); sawRst |= sysRst | portRst; end
    rstPin = 1'b0; for (int i = 0; i < lo1; i++) begin tick(1); sawRst |= sysRst | portRst; end
    rstPin = (hi2 > 0); for (int i = 0; i < hi2; i++) begin tick(1); sawRst |= sysRst | portRst; end
    rstPin = 1'b0; for (int i = 0; i < 40; i++) begin tick(1); sawRst |= sysRst | portRst; end
    chk(!sawRst, {tag, " no reset"}, sawRst, 0);
    chk(portsOut == portsSaved && sfrOut == sfrSaved && spOut == 8'h55,
        {tag, " registers unchanged"}, portsOut, portsSaved);
  endtask

  task automatic test_long_reset;
    int lat;
    int gap;
    lat = 0;
    rstPin = 1'b1;
    while (!sysRst && lat < 40) begin tick(1); lat++; end
    chk(lat >= 15 && lat <= 26, "R1 assert latency", lat, 15);
    chk(portsOut == 32'h13121110 && !portRst, "R3 ports held at reset start", portsOut, 32'h13121110);
    gap = 0;
    while (!portRst && gap < 40) begin
      tick(1); gap++;
      if (!portRst) chk(portsOut == 32'h13121110, "R3 ports held in window", portsOut, 32'h13121110);
    end
    chk(gap == 7, "R3 port delay after sysRst", gap, 7);
    tick(1);
    chk(portsOut == '1, "R3 ports forced", portsOut, 32'hFFFFFFFF);
    chk(spOut == 8'h07, "R5 sp reset value", spOut, 8'h07);
    chk(sfrOut == '0, "R5 bank reset value", sfrOut, 0);
    chk(sbufOut == 8'hA5, "R6 sbuf kept", sbufOut, 8'hA5);
    wr(4'd4, 8'h99);
    wr(4'd5, 8'h11);
    wr(4'd0, 8'h22);
    chk(spOut == 8'h07, "R7 sp write ignored", spOut, 8'h07);
    chk(sbufOut == 8'hA5, "R7 sbuf write ignored", sbufOut, 8'hA5);
    chk(portsOut[7:0] == 8'hFF, "R7 port write ignored", portsOut[7:0], 8'hFF);
    tick(60);
    chk(sysRst && portRst, "R1 reset held while pin high", {sysRst, portRst}, 3);
  endtask

  task automatic test_release;
    int lat;
    bit bothBefore;
    lat = 0;
    bothBefore = 1'b1;
    rstPin = 1'b0;
    while (sysRst && lat < 40) begin
      bothBefore = sysRst && portRst;
      tick(1); lat++;
    end
    chk(lat >= 3 && lat <= 14, "R4 release latency", lat, 3);
    chk(!portRst && bothBefore, "R4 port and core fall together", {bothBefore, portRst}, 2);
    wr(4'd1, 8'h5A);
    chk(portsOut[15:8] == 8'h5A, "R8 write after release", portsOut[15:8], 8'h5A);
  endtask

  task automatic test_min_reset;
    bit sawRst;
    sawRst = 1'b0;
    rstPin = 1'b1; tick(24);
    rstPin = 1'b0;
    for (int i = 0; i < 40; i++) begin
      sawRst |= sysRst;
      tick(1);
    end
    chk(sawRst, "R2 24-clock pin gives reset", sawRst, 1);
    chk(!sysRst, "R4 released after min reset", sysRst, 0);
  endtask

  initial begin
    tick(3);
    powerOnN = 1'b1;
    test_power_on();
    test_writes();
    test_glitch(12, 0, 0, "R2 single pulse");
    test_glitch(12, 12, 12, "R2 high-low-high");
    test_long_reset();
    test_release();
    test_min_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule